// File: doc/BRIEF.md
# Serial Switch-Chain Programmer

This block runs on the host side and programs a cascade of serial switch-control units. Each unit holds eight switch bits in a shift stage followed by a latch. All units share one serial clock. The serial output of each unit drives the serial input of the next, so the whole cascade acts as one long shift register of `N_UNITS*UNIT_BITS` bits. A start request loads a parallel pattern and shifts it out most-significant bit first, with the active-low latch strobe held inactive. After a programmed settling gap, the block pulses the strobe low for a programmed width and then reports completion.

A separate clear request overrides everything else. It aborts any load in progress and drives the dominant clear line high for a programmed number of system cycles. The serial clock is made by counting `half_period` system cycles per half-period, so the host can meet the serial-clock frequency limit of the units. Serial data changes only on falling edges.

The return line from the last unit is sampled at every serial-clock rise. After a complete load, `rx_word` therefore holds the contents the cascade had before the load.

Top module: `chain_ld`

## Requirements
- R1: After reset, `sclk_o`=0, `latch_n_o`=1, `clr_o`=0, `busy_o`=0, `done_o`=0 and `sdata_o`=0.
- R2: A start request accepted in idle produces exactly `N_UNITS*UNIT_BITS` serial-clock rises. The pattern is sent MSB first, so after the strobe bit k of `pattern` sits in chain position k, and pattern bit `N_UNITS*UNIT_BITS-1` lands on bit 7 of the last unit.
- R3: Each serial-clock high phase lasts exactly `half_period` system cycles. The first rise comes `half_period` cycles after `busy_o` rises, and later rises come every `2*half_period` cycles. `sdata_o` never changes while `sclk_o` is high.
- R4: `latch_n_o` stays high whenever `sclk_o` is high. It falls `latch_delay` system cycles after the final serial-clock fall and stays low for exactly `latch_width` cycles.
- R5: `busy_o` rises on the cycle after a start is accepted and falls on the cycle `latch_n_o` returns high. `done_o` is high for exactly that one cycle.
- R6: `chain_ret_i` is sampled before each serial-clock rise and shifted into the LSB of `rx_word`. After a full load, `rx_word` equals the cascade contents from before the load.
- R7: A clear request drives `clr_o` high for exactly `clear_width` system cycles. During that time `sclk_o` is 0, `latch_n_o` is 1 and `busy_o` is 1. The block then returns to idle without pulsing `done_o`.
- R8: A clear request during a load aborts it. No further serial-clock rises occur, `done_o` does not pulse, and the cascade ends cleared.
- R9: A start request while `busy_o` is high is ignored. The load in progress still produces exactly `N_UNITS*UNIT_BITS` rises and latches its own pattern.
- R10: When start and clear are requested in the same cycle, the clear wins and no serial-clock rise follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load the pattern into the cascade |
| clear_req | input | 1 | Request for a clear pulse; aborts any load |
| pattern | input | N_UNITS*UNIT_BITS | Switch pattern, MSB destined for the far end |
| half_period | input | LD_CNT_W | System cycles per serial-clock half period (>=1) |
| latch_delay | input | LD_CNT_W | Cycles from the final clock fall to the strobe fall (>=1) |
| latch_width | input | LD_CNT_W | Strobe low width in cycles (>=1) |
| clear_width | input | LD_CNT_W | Clear pulse width in cycles (>=1) |
| chain_ret_i | input | 1 | Serial output of the last unit in the cascade |
| busy_o | output | 1 | Load or clear in progress |
| done_o | output | 1 | One-cycle pulse when a load completes |
| sclk_o | output | 1 | Shared serial clock |
| sdata_o | output | 1 | Serial data to the first unit |
| latch_n_o | output | 1 | Active-low latch strobe |
| clr_o | output | 1 | Active-high clear line |
| rx_word | output | N_UNITS*UNIT_BITS | Bits returned from the cascade during the last load |

## Verification
The assertions assume that `start` and `clear_req` are one-cycle requests and that the four timing inputs are at least 1. They also assume those inputs are held constant while `busy_o` is high. A zero width would make the internal timer wrap, and a mid-run change would alter phase lengths. The stimulus writes the timing values only while the block is idle, always uses values of 1 or more, and pulses each request for exactly one system cycle. A behavioural model of the cascade, clocked by `sclk_o`, supplies `chain_ret_i` and reproduces the latch and clear behaviour of the units, so that load results, readback and abort effects are judged at the cascade itself.

// File: rtl/chain_ld_pkg.sv
package chain_ld_pkg;

    parameter int LD_CNT_W = 8;

    typedef logic [LD_CNT_W-1:0] ld_cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SH_LO,
        ST_SH_HI,
        ST_GAP,
        ST_LATCH,
        ST_CLR
    } ld_state_t;

    typedef struct packed {
        ld_cnt_t half;
        ld_cnt_t gap;
        ld_cnt_t le_w;
        ld_cnt_t clr_w;
    } ld_cfg_t;

    // phase length in system cycles for the given state
    function automatic ld_cnt_t ld_limit(ld_state_t s, ld_cfg_t c);
        case (s)
            ST_SH_LO, ST_SH_HI: return c.half;
            ST_GAP:             return c.gap;
            ST_LATCH:           return c.le_w;
            ST_CLR:             return c.clr_w;
            default:            return c.half;
        endcase
    endfunction

endpackage

// File: rtl/ld_timer.sv
module ld_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else                cnt <= cnt + W'(1);
    end

    // last cycle of a phase that is 'limit' cycles long
    assign hit = (cnt == limit - W'(1));
endmodule

// File: rtl/ld_serdes.sv
module ld_serdes #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] pattern,
    input  logic             shift,
    input  logic             capture,
    input  logic             ret_bit,
    output logic             tx_bit,
    output logic [WIDTH-1:0] rx_word
);
    logic [WIDTH-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst)        tx_q <= '0;
        else if (load)  tx_q <= pattern;
        else if (shift) tx_q <= {tx_q[WIDTH-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst)          rx_word <= '0;
        else if (capture) rx_word <= {rx_word[WIDTH-2:0], ret_bit};
    end

    assign tx_bit = tx_q[WIDTH-1];
endmodule

// File: rtl/chain_ld.sv
module chain_ld
    import chain_ld_pkg::*;
#(
    parameter int N_UNITS   = 2,
    parameter int UNIT_BITS = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic                           clear_req,
    input  logic [N_UNITS*UNIT_BITS-1:0]   pattern,
    input  logic [LD_CNT_W-1:0]            half_period,
    input  logic [LD_CNT_W-1:0]            latch_delay,
    input  logic [LD_CNT_W-1:0]            latch_width,
    input  logic [LD_CNT_W-1:0]            clear_width,
    input  logic                           chain_ret_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           sclk_o,
    output logic                           sdata_o,
    output logic                           latch_n_o,
    output logic                           clr_o,
    output logic [N_UNITS*UNIT_BITS-1:0]   rx_word
);
    localparam int TOTAL = N_UNITS * UNIT_BITS;
    localparam int BCW   = $clog2(TOTAL + 1);

    ld_state_t      state;
    ld_cfg_t        cfg;
    ld_cnt_t        limit;
    logic [BCW-1:0] bits_left;
    logic           hit, start_go, tmr_restart, do_shift, do_capture;

    always_comb begin
        cfg         = '{half: half_period, gap: latch_delay,
                        le_w: latch_width, clr_w: clear_width};
        limit       = ld_limit(state, cfg);
        start_go    = start && !clear_req && (state == ST_IDLE);
        tmr_restart = clear_req || start_go || hit;
        do_capture  = !clear_req && (state == ST_SH_LO) && hit;
        do_shift    = !clear_req && (state == ST_SH_HI) && hit;
    end

    ld_timer #(.W(LD_CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .limit   (limit),
        .hit     (hit)
    );

    ld_serdes #(.WIDTH(TOTAL)) u_serdes (
        .clk     (clk),
        .rst     (rst),
        .load    (start_go),
        .pattern (pattern),
        .shift   (do_shift),
        .capture (do_capture),
        .ret_bit (chain_ret_i),
        .tx_bit  (sdata_o),
        .rx_word (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sclk_o    <= 1'b0;
            latch_n_o <= 1'b1;
            clr_o     <= 1'b0;
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            bits_left <= '0;
        end else begin
            done_o <= 1'b0;
            if (clear_req) begin
                state     <= ST_CLR;
                clr_o     <= 1'b1;
                sclk_o    <= 1'b0;
                latch_n_o <= 1'b1;
                busy_o    <= 1'b1;
            end else begin
                case (state)
                    ST_IDLE: if (start) begin
                        state     <= ST_SH_LO;
                        busy_o    <= 1'b1;
                        bits_left <= BCW'(TOTAL);
                    end
                    ST_SH_LO: if (hit) begin
                        sclk_o <= 1'b1;
                        state  <= ST_SH_HI;
                    end
                    ST_SH_HI: if (hit) begin
                        sclk_o    <= 1'b0;
                        bits_left <= bits_left - BCW'(1);
                        state     <= (bits_left == BCW'(1)) ? ST_GAP : ST_SH_LO;
                    end
                    ST_GAP: if (hit) begin
                        latch_n_o <= 1'b0;
                        state     <= ST_LATCH;
                    end
                    ST_LATCH: if (hit) begin
                        latch_n_o <= 1'b1;
                        busy_o    <= 1'b0;
                        done_o    <= 1'b1;
                        state     <= ST_IDLE;
                    end
                    ST_CLR: if (hit) begin
                        clr_o  <= 1'b0;
                        busy_o <= 1'b0;
                        state  <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_STROBE_IDLE_WHILE_CLK: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> latch_n_o);                                                   // R4
    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));                         // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                                     // R5
    AST_DONE_AT_STROBE_END: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (latch_n_o && !busy_o && $past(!latch_n_o)));                 // R5
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_o && !clear_req) |=> (busy_o && !clr_o));                // R5
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        clr_o |-> (!sclk_o && latch_n_o && busy_o));                             // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clear_req |=> (clr_o && !done_o && !sclk_o));                            // R10
endmodule

// File: tb/chain_ld_test.sv
module chain_ld_test;
    localparam int NU = 2;
    localparam int UB = 8;
    localparam int T  = NU * UB;

    // {pattern, half_period, latch_delay, latch_width}
    localparam logic [39:0] VECS [4] = '{
        {16'hA5C3, 8'd2, 8'd1, 8'd1},
        {16'h8001, 8'd3, 8'd4, 8'd5},
        {16'hFFFF, 8'd1, 8'd2, 8'd3},
        {16'h0000, 8'd4, 8'd1, 8'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic start = 1'b0, clear_req = 1'b0;
    logic [T-1:0] pattern = '0;
    logic [7:0] cfg_h = 8'd2, cfg_d = 8'd1, cfg_w = 8'd1, cfg_c = 8'd3;
    logic busy, done, sclk, mosi, le_n, clr;
    logic [T-1:0] rx;
    logic [T-1:0] chain, lat;
    logic miso;

    always #2 clk = ~clk;

    chain_ld #(.N_UNITS(NU), .UNIT_BITS(UB)) uut (
        .clk(clk), .rst(rst), .start(start), .clear_req(clear_req),
        .pattern(pattern), .half_period(cfg_h), .latch_delay(cfg_d),
        .latch_width(cfg_w), .clear_width(cfg_c), .chain_ret_i(miso),
        .busy_o(busy), .done_o(done), .sclk_o(sclk), .sdata_o(mosi),
        .latch_n_o(le_n), .clr_o(clr), .rx_word(rx)
    );

    // cascade model: shift on serial clock rise, dominant clear, latch while strobe low
    always @(posedge sclk or posedge clr or posedge rst) begin
        if (rst || clr) chain <= '0;
        else            chain <= {chain[T-2:0], mosi};
    end
    assign miso = chain[T-1];

    always @(negedge clk) begin
        if (rst || clr) lat <= '0;
        else if (!le_n) lat <= chain;
    end

    // monitor: monotonic totals only
    int n_rise = 0, n_done = 0, n_per_err = 0, n_hi_err = 0, n_le_err = 0, n_mosi_err = 0;
    int cyc = 0, since = 0, hi_len = 0, le_len = 0, clr_len = 0, last_fall = 0;
    int last_gap = 0, last_le_len = 0, last_clr_len = 0;
    bit first = 1'b0;
    logic p_sclk = 1'b0, p_le = 1'b1, p_busy = 1'b0, p_mosi = 1'b0, p_clr = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (busy && !p_busy) begin since = 0; first = 1'b1; end
            else since++;
            if (sclk && !p_sclk) begin
                n_rise++;
                if (since != (first ? int'(cfg_h) : 2 * int'(cfg_h))) n_per_err++;
                since = 0; first = 1'b0; hi_len = 1;
            end else if (sclk) hi_len++;
            if (!sclk && p_sclk) begin
                if (hi_len != int'(cfg_h)) n_hi_err++;
                last_fall = cyc;
            end
            if (sclk && !le_n) n_le_err++;
            if (sclk && p_sclk && (mosi != p_mosi)) n_mosi_err++;
            if (!le_n && p_le) begin last_gap = cyc - last_fall; le_len = 1; end
            else if (!le_n) le_len++;
            if (le_n && !p_le) last_le_len = le_len;
            if (clr && !p_clr) clr_len = 1;
            else if (clr) clr_len++;
            if (!clr && p_clr) last_clr_len = clr_len;
            if (done) n_done++;
        end
        p_sclk = sclk; p_le = le_n; p_busy = busy; p_mosi = mosi; p_clr = clr;
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic chk_eq(input string what, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, what, act, exp);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk) clear_req = 1'b1;
        @(negedge clk) clear_req = 1'b0;
    endtask

    task automatic wait_idle(input int s_done, input bit want_done, input string what);
        bit ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (want_done ? (n_done > s_done) : !busy) begin ok = 1'b1; break; end
        end
        chk(ok, what, 0, 1);
        @(negedge clk);
    endtask

    task automatic run_load(input logic [T-1:0] p, input logic [7:0] h, d, w);
        logic [T-1:0] prev;
        int s_rise, s_done, s_per, s_hi, s_le, s_mo;
        cfg_h = h; cfg_d = d; cfg_w = w; pattern = p;
        prev = chain;
        s_rise = n_rise; s_done = n_done; s_per = n_per_err; s_hi = n_hi_err;
        s_le = n_le_err; s_mo = n_mosi_err;
        pulse_start();
        wait_idle(s_done, 1'b1, "R5 load completion");
        chk_eq("R2 serial clock rises", n_rise - s_rise, T);
        chk_eq("R2 latched pattern", lat, p);
        chk_eq("R2 far-end bit 7", lat[T-1], p[T-1]);
        chk_eq("R6 readback is previous contents", rx, prev);
        chk_eq("R3 clock period errors", (n_per_err - s_per) + (n_hi_err - s_hi), 0);
        chk_eq("R3 data change while clock high", n_mosi_err - s_mo, 0);
        chk_eq("R4 strobe low while clock high", n_le_err - s_le, 0);
        chk_eq("R4 settle gap", last_gap, d);
        chk_eq("R4 strobe width", last_le_len, w);
        chk_eq("R5 done pulses", n_done - s_done, 1);
        chk_eq("R5 busy after done", busy, 0);
    endtask

    initial begin
        #1 rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 sclk", sclk, 0);
        chk_eq("R1 strobe", le_n, 1);
        chk_eq("R1 clear line", clr, 0);
        chk_eq("R1 busy/done", {busy, done}, 2'b00);
        chk_eq("R1 data", mosi, 0);

        for (int i = 0; i < 4; i++)
            run_load(VECS[i][39:24], VECS[i][23:16], VECS[i][15:8], VECS[i][7:0]);

        // R9: second start while busy is ignored
        begin
            int s_rise, s_done;
            cfg_h = 8'd2; cfg_d = 8'd2; cfg_w = 8'd2; pattern = 16'h3C96;
            s_rise = n_rise; s_done = n_done;
            pulse_start();
            repeat (5) @(negedge clk);
            pattern = 16'h1111;
            pulse_start();
            wait_idle(s_done, 1'b1, "R9 completion");
            chk_eq("R9 rises unchanged by second start", n_rise - s_rise, T);
            chk_eq("R9 first pattern latched", lat, 16'h3C96);
            repeat (3) @(negedge clk);
            chk_eq("R9 no restart after done", busy, 0);
        end

        // R7: clear from idle
        begin
            int s_done;
            cfg_c = 8'd6; s_done = n_done;
            pulse_clear();
            chk_eq("R7 clear line and busy", {clr, busy, le_n, sclk}, 4'b1110);
            wait_idle(0, 1'b0, "R7 clear completion");
            chk_eq("R7 clear width", last_clr_len, 6);
            chk_eq("R7 no done", n_done - s_done, 0);
            chk_eq("R7 latches cleared", lat, 0);
        end

        // R8: clear aborts a load
        begin
            int s_rise, s_done;
            bit ok = 1'b0;
            cfg_h = 8'd3; cfg_c = 8'd4; pattern = 16'hFFFF;
            s_rise = n_rise; s_done = n_done;
            pulse_start();
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (n_rise - s_rise >= 5) begin ok = 1'b1; break; end
            end
            chk(ok, "R8 load underway", 0, 1);
            pulse_clear();
            s_rise = n_rise;
            wait_idle(0, 1'b0, "R8 abort completion");
            repeat (10) @(negedge clk);
            chk_eq("R8 no rises after abort", n_rise - s_rise, 0);
            chk_eq("R8 no done", n_done - s_done, 0);
            chk_eq("R8 cascade cleared", chain, 0);
            chk_eq("R8 lines idle", {sclk, le_n, clr, busy}, 4'b0100);
            chk_eq("R8 clear width", last_clr_len, 4);
        end

        // R10: clear and start in the same cycle
        begin
            int s_rise, s_done;
            s_rise = n_rise; s_done = n_done;
            @(negedge clk) begin start = 1'b1; clear_req = 1'b1; end
            @(negedge clk) begin start = 1'b0; clear_req = 1'b0; end
            chk_eq("R10 clear line wins", clr, 1);
            wait_idle(0, 1'b0, "R10 completion");
            repeat (10) @(negedge clk);
            chk_eq("R10 no serial clock", n_rise - s_rise, 0);
            chk_eq("R10 no done", n_done - s_done, 0);
        end

        // recovery after abort: readback reflects cleared cascade
        run_load(16'h5A0F, 8'd2, 8'd3, 8'd2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
        $finish;
    end
endmodule